// File: doc/BRIEF.md
# Cache Maintenance Error Arbiter

This block decides what a cache controller does with RAM errors found while it carries out a maintenance operation. Each request carries an operation code, the lookup result (hit and dirty), an error class for the tag RAM, the dirty RAM and every data word of the line, and two mode controls: force write-through and abort on correctable errors. One cycle after the request the block gives its verdict as one-cycle strobes. The verdict says whether the line is invalidated, whether a write-back starts and with which word enables, whether correctable or uncorrectable error events fire, and whether an asynchronous abort is raised.

The operation groups treat errors in different ways. Whole-cache invalidation ignores errors and stays silent. Set/way invalidation ignores errors but reports them. Lookup-based data-cache operations repair errors and can abort. Clean operations also guard the write-back against corrupt metadata. Coherency-port requests repair errors and report them, but never abort. The RAM accesses and the write-back datapath sit outside this block.

Top module: `cache_maint_err_arbiter`

## Requirements
- R1: After reset every output is 0. A request sampled with `req_valid_i` high yields its outputs on the following clock edge, and they hold for exactly one cycle. A cycle with `req_valid_i` low yields all-zero outputs on the next edge.
- R2: Error classes are 2'b00 none, 2'b01 correctable, and 2'b10 or 2'b11 uncorrectable. For reporting operations, `evt_cor_o` / `evt_unc_o` flag that at least one of tag, dirty or any data word holds that class.
- R3: Operation codes 1 (instruction cache, all) and 2 (data cache, all) assert `inval_o`. They signal no event, issue no write-back and never abort, whatever the errors.
- R4: Operation code 3 (instruction cache by address) invalidates when the lookup hits or when any error is present. It reports events and never aborts.
- R5: Operation code 4 (data cache invalidate by address) invalidates on a hit and reports events.
- R6: Operation code 5 (data cache invalidate by set/way) always invalidates, reports events and never aborts.
- R7: Clean operations are codes 6 (by address), 7 (by set/way), 8 (clean-invalidate by address) and 9 (clean-invalidate by set/way). They request a write-back when the line is targeted (a hit for 6 and 8, always for 7 and 9), the line is dirty, and neither the tag nor the dirty RAM has an uncorrectable error. Codes 8 and 9 also invalidate the targeted line.
- R8: With `force_wt_i` high the dirty flag is ignored, and clean operations request no write-back.
- R9: `wb_mask_o` bit i (data word i, error field bits [2i+1:2i]) is high exactly when a write-back is requested and word i has no uncorrectable error. With no write-back it is zero.
- R10: For codes 4 and 6–9, any uncorrectable error raises `abort_o`. A correctable error raises it only when `abort_en_i` is high.
- R11: Operation code 10 (coherency-port maintenance) invalidates only a line that hits and is not dirty. It reports events, and it never aborts and never writes back.
- R12: Codes 0 and 11–15 produce no invalidation, write-back, event or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 4 | Maintenance operation code |
| line_hit_i | input | 1 | Lookup found the address |
| line_dirty_i | input | 1 | Target line is dirty |
| tag_err_i | input | 2 | Tag RAM error class |
| dirty_err_i | input | 2 | Dirty RAM error class |
| data_err_i | input | 2*NUM_WORDS | Per-word data RAM error classes |
| force_wt_i | input | 1 | Force write-through mode |
| abort_en_i | input | 1 | Abort on correctable errors |
| inval_o | output | 1 | Invalidate target line strobe |
| wb_req_o | output | 1 | Write-back request strobe |
| wb_mask_o | output | NUM_WORDS | Per-word write enables for the write-back |
| evt_cor_o | output | 1 | Correctable error event strobe |
| evt_unc_o | output | 1 | Uncorrectable error event strobe |
| abort_o | output | 1 | Asynchronous abort strobe |

## Verification
The bench attacks the corner cases where the operation groups diverge. An uncorrectable tag error on a whole-cache invalidate must stay silent; a design that reported it would raise a spurious event. A doubly-uncorrectable code 2'b11 in the dirty RAM must block a write-back; a design decoding only 2'b10 would write corrupt data. Force write-through must suppress a dirty clean, and a corrupt data word must drop only its own mask bit, not the whole line. A correctable error must abort only with the enable set, and a dirty coherency hit must be kept, while unknown codes and idle cycles must leave every strobe low.

// File: rtl/cmea_pkg.sv
package cmea_pkg;

   localparam int unsigned OP_W  = 4;
   localparam int unsigned ERR_W = 2;

   localparam logic [OP_W-1:0] OP_IC_INV_ALL = 4'd1;
   localparam logic [OP_W-1:0] OP_DC_INV_ALL = 4'd2;
   localparam logic [OP_W-1:0] OP_IC_INV_VA  = 4'd3;
   localparam logic [OP_W-1:0] OP_DC_INV_VA  = 4'd4;
   localparam logic [OP_W-1:0] OP_DC_INV_SW  = 4'd5;
   localparam logic [OP_W-1:0] OP_DC_CLN_VA  = 4'd6;
   localparam logic [OP_W-1:0] OP_DC_CLN_SW  = 4'd7;
   localparam logic [OP_W-1:0] OP_DC_CI_VA   = 4'd8;
   localparam logic [OP_W-1:0] OP_DC_CI_SW   = 4'd9;
   localparam logic [OP_W-1:0] OP_COH_MAINT  = 4'd10;

   // how the target line is dropped for a given operation
   typedef enum logic [2:0] {
      INV_NEVER      = 3'd0,
      INV_ALWAYS     = 3'd1,
      INV_ON_HIT     = 3'd2,
      INV_HIT_OR_ERR = 3'd3,
      INV_HIT_CLEAN  = 3'd4
   } inv_mode_e;

   typedef struct packed {
      logic      known;
      inv_mode_e inv;
      logic      report;
      logic      may_abort;
      logic      clean;
      logic      need_hit;
   } op_policy_t;

   typedef struct packed {
      logic any_cor;
      logic any_unc;
      logic meta_unc;
   } err_summary_t;

   typedef struct packed {
      logic inval;
      logic wb;
      logic cor;
      logic unc;
      logic abort;
   } decision_t;

   function automatic logic err_is_unc(input logic [ERR_W-1:0] e);
      return e[1];
   endfunction

   function automatic logic err_is_cor(input logic [ERR_W-1:0] e);
      return (e == 2'b01);
   endfunction

endpackage

// File: rtl/cmea_op_decode.sv
module cmea_op_decode
   import cmea_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output op_policy_t      pol_o
);

   always_comb begin
      pol_o = '0;
      pol_o.inv = INV_NEVER;
      case (op_i)
         OP_IC_INV_ALL, OP_DC_INV_ALL: begin
            pol_o.known = 1'b1;
            pol_o.inv   = INV_ALWAYS;
         end
         OP_IC_INV_VA: begin
            pol_o.known  = 1'b1;
            pol_o.inv    = INV_HIT_OR_ERR;
            pol_o.report = 1'b1;
         end
         OP_DC_INV_VA: begin
            pol_o.known     = 1'b1;
            pol_o.inv       = INV_ON_HIT;
            pol_o.report    = 1'b1;
            pol_o.may_abort = 1'b1;
         end
         OP_DC_INV_SW: begin
            pol_o.known  = 1'b1;
            pol_o.inv    = INV_ALWAYS;
            pol_o.report = 1'b1;
         end
         OP_DC_CLN_VA: begin
            pol_o.known     = 1'b1;
            pol_o.report    = 1'b1;
            pol_o.may_abort = 1'b1;
            pol_o.clean     = 1'b1;
            pol_o.need_hit  = 1'b1;
         end
         OP_DC_CLN_SW: begin
            pol_o.known     = 1'b1;
            pol_o.report    = 1'b1;
            pol_o.may_abort = 1'b1;
            pol_o.clean     = 1'b1;
         end
         OP_DC_CI_VA: begin
            pol_o.known     = 1'b1;
            pol_o.inv       = INV_ON_HIT;
            pol_o.report    = 1'b1;
            pol_o.may_abort = 1'b1;
            pol_o.clean     = 1'b1;
            pol_o.need_hit  = 1'b1;
         end
         OP_DC_CI_SW: begin
            pol_o.known     = 1'b1;
            pol_o.inv       = INV_ALWAYS;
            pol_o.report    = 1'b1;
            pol_o.may_abort = 1'b1;
            pol_o.clean     = 1'b1;
         end
         OP_COH_MAINT: begin
            pol_o.known  = 1'b1;
            pol_o.inv    = INV_HIT_CLEAN;
            pol_o.report = 1'b1;
         end
         default: pol_o = '0; // R12: unknown codes do nothing
      endcase
   end

endmodule

// File: rtl/cmea_err_reduce.sv
module cmea_err_reduce
   import cmea_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 4
)(
   input  logic [ERR_W-1:0]           tag_err_i,
   input  logic [ERR_W-1:0]           dirty_err_i,
   input  logic [NUM_WORDS*ERR_W-1:0] data_err_i,
   output err_summary_t               summ_o,
   output logic [NUM_WORDS-1:0]       word_unc_o
);

   logic [NUM_WORDS-1:0] word_cor;
   logic                 meta_unc;
   logic                 meta_cor;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_unc_o[w] = err_is_unc(data_err_i[w*ERR_W +: ERR_W]);
      assign word_cor[w]   = err_is_cor(data_err_i[w*ERR_W +: ERR_W]);
   end

   assign meta_unc = err_is_unc(tag_err_i) | err_is_unc(dirty_err_i);
   assign meta_cor = err_is_cor(tag_err_i) | err_is_cor(dirty_err_i);

   assign summ_o.meta_unc = meta_unc;
   assign summ_o.any_unc  = meta_unc | (|word_unc_o);
   assign summ_o.any_cor  = meta_cor | (|word_cor);

endmodule

// File: rtl/cmea_decide.sv
module cmea_decide
   import cmea_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 4
)(
   input  op_policy_t           pol_i,
   input  err_summary_t         summ_i,
   input  logic [NUM_WORDS-1:0] word_unc_i,
   input  logic                 hit_i,
   input  logic                 dirty_i,
   input  logic                 force_wt_i,
   input  logic                 abort_en_i,
   output decision_t            dec_o,
   output logic [NUM_WORDS-1:0] mask_o
);

   logic target;
   logic eff_dirty;
   logic any_err;

   assign target    = pol_i.need_hit ? hit_i : 1'b1;
   assign eff_dirty = dirty_i & ~force_wt_i;
   assign any_err   = summ_i.any_cor | summ_i.any_unc;

   always_comb begin
      dec_o = '0;
      if (pol_i.known) begin
         case (pol_i.inv)
            INV_ALWAYS:     dec_o.inval = 1'b1;
            INV_ON_HIT:     dec_o.inval = hit_i;
            INV_HIT_OR_ERR: dec_o.inval = hit_i | any_err;
            INV_HIT_CLEAN:  dec_o.inval = hit_i & ~dirty_i;
            default:        dec_o.inval = 1'b0;
         endcase
         dec_o.wb    = pol_i.clean & target & eff_dirty & ~summ_i.meta_unc;
         dec_o.cor   = pol_i.report & summ_i.any_cor;
         dec_o.unc   = pol_i.report & summ_i.any_unc;
         dec_o.abort = pol_i.may_abort &
                       (summ_i.any_unc | (summ_i.any_cor & abort_en_i));
      end
   end

   assign mask_o = dec_o.wb ? ~word_unc_i : '0;

endmodule

// File: rtl/cache_maint_err_arbiter.sv
module cache_maint_err_arbiter
   import cmea_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid_i,
   input  logic [3:0]                 req_op_i,
   input  logic                       line_hit_i,
   input  logic                       line_dirty_i,
   input  logic [1:0]                 tag_err_i,
   input  logic [1:0]                 dirty_err_i,
   input  logic [2*NUM_WORDS-1:0]     data_err_i,
   input  logic                       force_wt_i,
   input  logic                       abort_en_i,
   output logic                       inval_o,
   output logic                       wb_req_o,
   output logic [NUM_WORDS-1:0]       wb_mask_o,
   output logic                       evt_cor_o,
   output logic                       evt_unc_o,
   output logic                       abort_o
);

   if (NUM_WORDS < 1 || NUM_WORDS > 64) begin : g_bad_words
      $error("NUM_WORDS must lie in 1..64");
   end
   if (OP_W != 4 || ERR_W != 2) begin : g_bad_pkg
      $error("port widths disagree with package widths");
   end

   op_policy_t           pol;
   err_summary_t         summ;
   logic [NUM_WORDS-1:0] word_unc;
   decision_t            dec_d, dec_q;
   logic [NUM_WORDS-1:0] mask_d, mask_q;

   cmea_op_decode u_decode (
      .op_i  (req_op_i),
      .pol_o (pol)
   );

   cmea_err_reduce #(.NUM_WORDS(NUM_WORDS)) u_reduce (
      .tag_err_i   (tag_err_i),
      .dirty_err_i (dirty_err_i),
      .data_err_i  (data_err_i),
      .summ_o      (summ),
      .word_unc_o  (word_unc)
   );

   cmea_decide #(.NUM_WORDS(NUM_WORDS)) u_decide (
      .pol_i      (pol),
      .summ_i     (summ),
      .word_unc_i (word_unc),
      .hit_i      (line_hit_i),
      .dirty_i    (line_dirty_i),
      .force_wt_i (force_wt_i),
      .abort_en_i (abort_en_i),
      .dec_o      (dec_d),
      .mask_o     (mask_d)
   );

   // R1: one register stage, strobes cleared when no request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q  <= '0;
         mask_q <= '0;
      end else if (req_valid_i) begin
         dec_q  <= dec_d;
         mask_q <= mask_d;
      end else begin
         dec_q  <= '0;
         mask_q <= '0;
      end
   end

   assign inval_o   = dec_q.inval;
   assign wb_req_o  = dec_q.wb;
   assign wb_mask_o = mask_q;
   assign evt_cor_o = dec_q.cor;
   assign evt_unc_o = dec_q.unc;
   assign abort_o   = dec_q.abort;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !(inval_o || wb_req_o || evt_cor_o || evt_unc_o || abort_o));

   a_r3_inv_all_silent: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && (req_op_i == OP_IC_INV_ALL || req_op_i == OP_DC_INV_ALL)
      |=> inval_o && !wb_req_o && !evt_cor_o && !evt_unc_o && !abort_o);

   a_r7_meta_unc_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && (tag_err_i[1] || dirty_err_i[1]) |=> !wb_req_o);

   a_r8_fwt_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && force_wt_i |=> !wb_req_o);

   a_r9_mask_needs_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_mask_o != '0) |-> wb_req_o);

   a_r10_unc_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && summ.any_unc &&
      (req_op_i == OP_DC_INV_VA || (req_op_i >= OP_DC_CLN_VA && req_op_i <= OP_DC_CI_SW))
      |=> abort_o);

   a_r11_coh_never_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && req_op_i == OP_COH_MAINT |=> !abort_o && !wb_req_o);

   a_r12_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && (req_op_i == 4'd0 || req_op_i > OP_COH_MAINT)
      |=> !(inval_o || wb_req_o || evt_cor_o || evt_unc_o || abort_o));

endmodule

// File: tb/cache_maint_err_arbiter_tb_top.sv
module cache_maint_err_arbiter_tb_top;

   localparam int NW   = 4;
   localparam int NVEC = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid_i = 1'b0;
   logic [3:0]    req_op_i = '0;
   logic          line_hit_i = 1'b0;
   logic          line_dirty_i = 1'b0;
   logic [1:0]    tag_err_i = '0;
   logic [1:0]    dirty_err_i = '0;
   logic [2*NW-1:0] data_err_i = '0;
   logic          force_wt_i = 1'b0;
   logic          abort_en_i = 1'b0;
   logic          inval_o, wb_req_o, evt_cor_o, evt_unc_o, abort_o;
   logic [NW-1:0] wb_mask_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   cache_maint_err_arbiter #(.NUM_WORDS(NW)) dut_i (
      .clk, .rst_n, .req_valid_i, .req_op_i, .line_hit_i, .line_dirty_i,
      .tag_err_i, .dirty_err_i, .data_err_i, .force_wt_i, .abort_en_i,
      .inval_o, .wb_req_o, .wb_mask_o, .evt_cor_o, .evt_unc_o, .abort_o
   );

   // {req, op, hit, dirty, tag, drt, data, fwt, aen, | inval, wb, mask, cor, unc, abort}
   localparam logic [32:0] VEC [NVEC] = '{
      {4'd3,  4'd1, 1'b1,1'b1, 2'b10,2'b01, 8'h01, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b0,1'b0,1'b0}, // R3
      {4'd3,  4'd2, 1'b1,1'b1, 2'b00,2'b00, 8'h02, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b0,1'b0,1'b0}, // R3
      {4'd4,  4'd3, 1'b0,1'b0, 2'b01,2'b00, 8'h00, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b1,1'b0,1'b0}, // R4
      {4'd4,  4'd3, 1'b0,1'b0, 2'b00,2'b00, 8'h00, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}, // R4
      {4'd4,  4'd3, 1'b1,1'b0, 2'b00,2'b00, 8'h80, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b0,1'b1,1'b0}, // R4
      {4'd5,  4'd4, 1'b1,1'b0, 2'b00,2'b00, 8'h00, 1'b0,1'b0, 1'b1,1'b0,4'h0,1'b0,1'b0,1'b0}, // R5
      {4'd10, 4'd4, 1'b0,1'b0, 2'b01,2'b00, 8'h00, 1'b0,1'b0, 1'b0,1'b0,4'h0,1'b1,1'b0,1'b0}, // R10
      {4'd10, 4'd4, 1'b0,1'b0, 2'b01,2'b00, 8'h00, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b1,1'b0,1'b1}, // R10
      {4'd5,  4'd4, 1'b1,1'b0, 2'b00,2'b10, 8'h00, 1'b0,1'b0, 1'b1,1'b0,4'h0,1'b0,1'b1,1'b1}, // R5
      {4'd6,  4'd5, 1'b0,1'b0, 2'b00,2'b00, 8'h0A, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b0,1'b1,1'b0}, // R6
      {4'd7,  4'd6, 1'b1,1'b1, 2'b00,2'b00, 8'h00, 1'b0,1'b0, 1'b0,1'b1,4'hF,1'b0,1'b0,1'b0}, // R7
      {4'd7,  4'd6, 1'b0,1'b1, 2'b00,2'b00, 8'h00, 1'b0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}, // R7
      {4'd7,  4'd7, 1'b0,1'b1, 2'b00,2'b00, 8'h00, 1'b0,1'b0, 1'b0,1'b1,4'hF,1'b0,1'b0,1'b0}, // R7
      {4'd7,  4'd8, 1'b1,1'b1, 2'b10,2'b00, 8'h00, 1'b0,1'b0, 1'b1,1'b0,4'h0,1'b0,1'b1,1'b1}, // R7
      {4'd2,  4'd9, 1'b0,1'b1, 2'b00,2'b11, 8'h00, 1'b0,1'b0, 1'b1,1'b0,4'h0,1'b0,1'b1,1'b1}, // R2
      {4'd8,  4'd6, 1'b1,1'b1, 2'b00,2'b00, 8'h00, 1'b1,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}, // R8
      {4'd8,  4'd9, 1'b1,1'b1, 2'b00,2'b00, 8'h01, 1'b1,1'b1, 1'b1,1'b0,4'h0,1'b1,1'b0,1'b1}, // R8
      {4'd9,  4'd6, 1'b1,1'b1, 2'b00,2'b00, 8'h20, 1'b0,1'b0, 1'b0,1'b1,4'hB,1'b0,1'b1,1'b1}, // R9
      {4'd9,  4'd7, 1'b0,1'b1, 2'b00,2'b00, 8'h44, 1'b0,1'b0, 1'b0,1'b1,4'hF,1'b1,1'b0,1'b0}, // R9
      {4'd9,  4'd8, 1'b1,1'b1, 2'b01,2'b00, 8'h02, 1'b0,1'b0, 1'b1,1'b1,4'hE,1'b1,1'b1,1'b1}, // R9
      {4'd11, 4'd10,1'b1,1'b0, 2'b01,2'b00, 8'h00, 1'b0,1'b1, 1'b1,1'b0,4'h0,1'b1,1'b0,1'b0}, // R11
      {4'd11, 4'd10,1'b1,1'b1, 2'b00,2'b00, 8'h02, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b1,1'b0}, // R11
      {4'd12, 4'd0, 1'b1,1'b1, 2'b10,2'b00, 8'h00, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}, // R12
      {4'd12, 4'd15,1'b1,1'b1, 2'b10,2'b00, 8'h00, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}, // R12
      {4'd12, 4'd11,1'b1,1'b1, 2'b00,2'b00, 8'h01, 1'b0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}  // R12
   };

   function automatic logic [8:0] outs();
      return {inval_o, wb_req_o, wb_mask_o, evt_cor_o, evt_unc_o, abort_o};
   endfunction

   task automatic check(input int req, input logic [8:0] exp, input string what);
      total++;
      if (outs() !== exp) begin
         bad++;
         $display("FAIL R%0d %s actual=%b expected=%b", req, what, outs(), exp);
      end
   endtask

   task automatic drive(input logic [32:0] v);
      req_valid_i  = 1'b1;
      req_op_i     = v[28:25];
      line_hit_i   = v[24];
      line_dirty_i = v[23];
      tag_err_i    = v[22:21];
      dirty_err_i  = v[20:19];
      data_err_i   = v[18:11];
      force_wt_i   = v[10];
      abort_en_i   = v[9];
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(1, 9'h000, "R1 outputs during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 9'h000, "R1 outputs after reset");

      // table walk: drive, check one cycle later, then check the strobe drops
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i]);
         @(negedge clk);
         req_valid_i = 1'b0;
         check(int'(VEC[i][32:29]), VEC[i][8:0], $sformatf("vector %0d", i));
         @(negedge clk);
         check(1, 9'h000, $sformatf("R1 strobe after vector %0d", i));
      end

      // R1: stimulus without valid has no effect
      drive(VEC[0]);
      req_valid_i = 1'b0;
      @(negedge clk);
      check(1, 9'h000, "R1 invalid request ignored");

      // R1: back-to-back requests each give their own verdict
      drive(VEC[0]);
      @(negedge clk);
      check(1, VEC[0][8:0], "R1 back-to-back first");
      drive(VEC[3]);
      @(negedge clk);
      check(1, VEC[3][8:0], "R1 back-to-back second");
      req_valid_i = 1'b0;

      // R1: reset mid-stream clears a pending strobe
      drive(VEC[10]);
      @(posedge clk);
      #1 rst_n = 1'b0;
      #1 check(1, 9'h000, "R1 asynchronous reset clears outputs");
      req_valid_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 9'h000, "R1 quiet after second reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule